// File: doc/BRIEF.md
# UART Receive Interrupt Controller

This block raises the receive-side interrupt of a UART whose receiver runs with a FIFO. It works out what needs service from four sources: the FIFO fill level measured against a programmed trigger level, the FIFO read and write strobes, per-character line error flags, and an idle timer. It then drives one request line and a 3-bit identification code. The timer counts 16x baud ticks in units of a character time. The block derives the character time itself from the programmed word length and the parity enable.

When the FIFO crosses up to its trigger level, the data-ready cause is raised. Software may read some characters and leave the FIFO at or above the trigger level. If it then leaves the FIFO untouched for four character times, data-ready is raised again, so a stalled drain is not lost. When the FIFO holds data below the trigger level and sits idle for the same window, a receive time-out cause is raised instead. Line errors latch a line-status cause, which outranks both other causes until software acknowledges it.

Top module: `rx_irq_ctrl`

## Requirements
- R1: One clock edge after `fifo_level >= trig_level` becomes true (it was false in the previous cycle, or reset has just ended), `irq_id` reads 3'b010 and `irq` is high.
- R2: One clock edge after any cycle with `fifo_level < trig_level`, the data-ready cause (3'b010) is not reported.
- R3: A `fifo_rd` pulse clears the data-ready cause even if the level stays at or above the trigger. Data-ready is raised again on exactly the four-character-time tick after the last FIFO access, and not on any earlier tick, provided the level stays at or above the trigger.
- R4: One character time is 16 × (1 start + n data + p parity + 1 stop) baud ticks. Here n = 5 + `word_len` (2'b00 = 5 bits up to 2'b11 = 8 bits) and p = `parity_en`. The idle window is four character times.
- R5: The idle count restarts from zero on every `fifo_rd` or `fifo_wr`. It stays at zero while `fifo_level` is 0, and it advances only on cycles with `baud16_tick` high.
- R6: Any bit of `line_err` high (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break) makes `irq_id` read 3'b011 one edge later. The line-status cause stays set until a `lsr_rd` pulse comes in a cycle with no error bit set.
- R7: When the idle window expires while 0 < `fifo_level` < `trig_level`, `irq_id` reads 3'b110 one edge later. A `fifo_rd` clears it on the next edge.
- R8: Priority is line status (3'b011), then data-ready (3'b010), then time-out (3'b110). With nothing pending, `irq` is low, `irq_id` is 3'b000 and `none_pending` is high. Otherwise `none_pending` is low and `irq` is high.
- R9: After reset, nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud16_tick | input | 1 | One-cycle pulse at 16 times the baud rate |
| fifo_level | input | LVL_W | Current receive FIFO fill level |
| trig_level | input | LVL_W | Programmed trigger level (1 or more) |
| fifo_wr | input | 1 | Character written into the receive FIFO |
| fifo_rd | input | 1 | Character read from the receive FIFO |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present in the frame |
| line_err | input | 4 | Error pulses: overrun, parity, framing, break |
| lsr_rd | input | 1 | Line-status read acknowledge |
| irq | output | 1 | Interrupt request |
| irq_id | output | 3 | Highest-priority pending cause |
| none_pending | output | 1 | No cause pending |

## Verification
Every cause is held in a register, and the outputs decode those registers directly. So the effect of a level change, an error pulse, a read or an acknowledge is due exactly one clock edge after the cycle that carries it. The bench drives inputs just after a rising edge and samples one edge later. The idle window is checked by counting the baud ticks the bench issues itself. For every word length and parity setting, the bench confirms that nothing has changed after one tick less than the computed window, and that the expected cause appears right after the final tick. Because ticks arrive only every other cycle, a design that counted clocks instead of ticks would be caught.

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl #(
  parameter int LVL_W    = 5,
  parameter int OVS      = 16,
  parameter int TO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud16_tick,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] trig_level,
  input  logic             fifo_wr,
  input  logic             fifo_rd,
  input  logic [1:0]       word_len,
  input  logic             parity_en,
  input  logic [3:0]       line_err,
  input  logic             lsr_rd,
  output logic             irq,
  output logic [2:0]       irq_id,
  output logic             none_pending
);
  localparam int MAX_BITS = 11;
  localparam int CNT_W    = $clog2(TO_CHARS * OVS * MAX_BITS + 1);
  localparam logic [2:0] ID_LS   = 3'b011;
  localparam logic [2:0] ID_DR   = 3'b010;
  localparam logic [2:0] ID_TO   = 3'b110;
  localparam logic [2:0] ID_NONE = 3'b000;

  logic [3:0]       frame_bits;
  logic [CNT_W-1:0] limit, idle_cnt;
  logic             above, held, access, to_evt;
  logic             above_q, dr_pend, to_pend, ls_pend;

  assign frame_bits = 4'd7 + {2'b00, word_len} + {3'b000, parity_en};
  assign limit      = CNT_W'(TO_CHARS * OVS * int'(frame_bits));
  assign above      = fifo_level >= trig_level;
  assign held       = fifo_level != '0;
  assign access     = fifo_rd | fifo_wr;
  assign to_evt     = baud16_tick && !access && held && (idle_cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (access || !held)   idle_cnt <= '0;
    else if (to_evt)            idle_cnt <= '0;
    else if (baud16_tick)       idle_cnt <= idle_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= 1'b0;
      dr_pend <= 1'b0;
      to_pend <= 1'b0;
      ls_pend <= 1'b0;
    end else begin
      above_q <= above;

      if (!above)                      dr_pend <= 1'b0;
      else if (!above_q || to_evt)     dr_pend <= 1'b1;
      else if (fifo_rd)                dr_pend <= 1'b0;

      if (fifo_rd || above)            to_pend <= 1'b0;
      else if (to_evt)                 to_pend <= 1'b1;

      if (|line_err)                   ls_pend <= 1'b1;
      else if (lsr_rd)                 ls_pend <= 1'b0;
    end
  end

  always_comb begin
    if (ls_pend)      irq_id = ID_LS;
    else if (dr_pend) irq_id = ID_DR;
    else if (to_pend) irq_id = ID_TO;
    else              irq_id = ID_NONE;
  end

  assign none_pending = !(ls_pend || dr_pend || to_pend);
  assign irq          = !none_pending;
endmodule

// File: rtl/rx_irq_ctrl_chk.sv
module rx_irq_ctrl_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] fifo_level,
  input logic [LVL_W-1:0] trig_level,
  input logic             fifo_rd,
  input logic [3:0]       line_err,
  input logic             lsr_rd,
  input logic             irq,
  input logic [2:0]       irq_id,
  input logic             none_pending
);
  p_below_no_dr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level < trig_level) |=> (irq_id != 3'b010));

  p_err_sets_ls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_err) |=> (irq_id == 3'b011 && irq));

  p_ls_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id == 3'b011 && !lsr_rd) |=> (irq_id == 3'b011));

  p_read_clears_to_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> (irq_id != 3'b110));

  p_idle_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    none_pending |-> (!irq && irq_id == 3'b000));

  p_busy_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !none_pending |-> (irq && irq_id != 3'b000));
endmodule

bind rx_irq_ctrl rx_irq_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .trig_level(trig_level),
  .fifo_rd(fifo_rd), .line_err(line_err), .lsr_rd(lsr_rd), .irq(irq),
  .irq_id(irq_id), .none_pending(none_pending)
);

// File: tb/rx_irq_ctrl_bench.sv
module rx_irq_ctrl_bench;
  localparam int LVL_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             baud16_tick = 1'b0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic [LVL_W-1:0] trig_level = 5'd8;
  logic             fifo_wr = 1'b0;
  logic             fifo_rd = 1'b0;
  logic [1:0]       word_len = 2'd0;
  logic             parity_en = 1'b0;
  logic [3:0]       line_err = 4'd0;
  logic             lsr_rd = 1'b0;
  logic             irq;
  logic [2:0]       irq_id;
  logic             none_pending;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_irq_ctrl #(.LVL_W(LVL_W)) u_rx_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .baud16_tick(baud16_tick), .fifo_level(fifo_level),
    .trig_level(trig_level), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .word_len(word_len),
    .parity_en(parity_en), .line_err(line_err), .lsr_rd(lsr_rd), .irq(irq),
    .irq_id(irq_id), .none_pending(none_pending)
  );

  task automatic chk(input string req, input logic [2:0] exp_id);
    logic exp_irq;
    exp_irq = (exp_id != 3'b000);
    checks++;
    if (irq_id !== exp_id || irq !== exp_irq || none_pending !== !exp_irq) begin
      errors++;
      $display("FAIL %s wl=%0d par=%0d: id=%b irq=%b none=%b expected id=%b irq=%b none=%b",
               req, word_len, parity_en, irq_id, irq, none_pending, exp_id, exp_irq, !exp_irq);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run_ticks(input int n);
    repeat (n) begin
      baud16_tick = 1'b1; step();
      baud16_tick = 1'b0; step();
    end
  endtask

  task automatic pulse_rd(input logic [LVL_W-1:0] new_level);
    fifo_rd = 1'b1; fifo_level = new_level; step();
    fifo_rd = 1'b0;
  endtask

  task automatic pulse_err(input int b);
    line_err = 4'd0; line_err[b] = 1'b1; step();
    line_err = 4'd0;
  endtask

  task automatic pulse_ack();
    lsr_rd = 1'b1; step();
    lsr_rd = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int cfg = 0; cfg < 8; cfg++) begin
      int lim;
      word_len = 2'(cfg % 4);
      parity_en = 1'(cfg / 4);
      lim = 4 * 16 * (7 + int'(word_len) + int'(parity_en));
      fifo_level = '0; trig_level = 5'd8;
      rst_n = 1'b0; step(); step();
      rst_n = 1'b1; step();
      chk("R9 reset", 3'b000);

      // R7/R4/R5: time-out below trigger, window timed from a write
      fifo_level = 5'd3; fifo_wr = 1'b1; step(); fifo_wr = 1'b0;
      run_ticks(lim / 2);
      fifo_wr = 1'b1; step(); fifo_wr = 1'b0;
      run_ticks(lim - 1);
      chk("R5 write restarts idle count", 3'b000);
      run_ticks(1);
      chk("R7 R4 time-out after four char times", 3'b110);
      pulse_err(cfg % 4);
      chk("R8 line status over time-out", 3'b011);
      pulse_ack();
      chk("R8 time-out shows after ack", 3'b110);
      pulse_rd(5'd2);
      chk("R7 read clears time-out", 3'b000);

      // R5: count holds while empty
      fifo_level = '0;
      run_ticks(lim + 5);
      chk("R5 empty FIFO never times out", 3'b000);
      fifo_level = 5'd3;
      run_ticks(lim - 1);
      chk("R5 count started at zero", 3'b000);
      run_ticks(1);
      chk("R7 time-out after hold", 3'b110);
      pulse_rd(5'd0);
      chk("R7 read to empty clears", 3'b000);

      // R1/R3/R2: data-ready
      fifo_level = 5'd8; step();
      chk("R1 trigger reached", 3'b010);
      pulse_rd(5'd9);
      chk("R3 read clears data-ready", 3'b000);
      run_ticks(lim - 1);
      chk("R3 not before window", 3'b000);
      run_ticks(1);
      chk("R3 R4 data-ready re-raised", 3'b010);
      fifo_level = 5'd7; step();
      chk("R2 below trigger clears", 3'b000);

      // R6/R8: line status over data-ready
      fifo_level = 5'd8; step();
      chk("R1 trigger reached again", 3'b010);
      for (int b = 0; b < 4; b++) begin
        pulse_err(b);
        chk("R6 error raises line status", 3'b011);
        step(); step(); step();
        chk("R6 line status stays latched", 3'b011);
        pulse_ack();
        chk("R8 data-ready after ack", 3'b010);
      end
      line_err = 4'b0100; lsr_rd = 1'b1; step();
      line_err = 4'd0; lsr_rd = 1'b0;
      chk("R6 error wins over same-cycle ack", 3'b011);
      pulse_ack();
      chk("R6 ack clears", 3'b010);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule